// File: doc/BRIEF.md
# Legacy Display Address Forwarding Decoder

This block sits in the address decode path of a two-sided bus bridge. On every clock it looks at one request address and its space (memory or I/O), and decides two things: whether a request seen on the primary side should be passed down to the secondary side, and whether a request seen on the secondary side must be kept from travelling up to the primary side. The decision combines a claim on the fixed legacy display ranges with the hit flags that the bridge's existing base/limit window comparators already produce.

When the legacy display claim is switched on, the display memory hole and the display I/O ports are forwarded downstream without regard to the windows or to the ISA alias setting. The same addresses are also marked as blocked in the upstream direction. A separate control bit chooses whether I/O address bits [15:10] are ignored, so that every 1 KB alias matches, or are decoded in full. Both results are registered. Configuration storage and the window comparators live outside the block.

Top module: `vga_route_dec`

## Requirements
- R1: With `req_is_io`=0 (memory), `vga_en`=1 and `cmd_mem_en`=1, an address from 000A_0000h to 000B_FFFFh inclusive sets `fwd_down`. 0009_FFFFh and 000C_0000h do not match, and an I/O request at a memory address in that range does not match either.
- R2: With `req_is_io`=1 (I/O), a legacy display I/O match needs address bits [31:16] to be zero and bits [9:0] to fall in 3B0h..3BBh or 3C0h..3DFh, both ranges inclusive. 3AFh, 3BCh, 3BFh and 3E0h do not match.
- R3: With `vga_full_dec`=0, bits [15:10] are ignored, so an alias such as FFC0h matches like 03C0h.
- R4: With `vga_full_dec`=1, bits [15:10] must all be zero for an I/O match. The bit changes nothing while `vga_en`=0.
- R5: A legacy display match forwards downstream whatever the window hit flags and `isa_en` are. With `vga_en`=0 the ranges are forwarded only through a window hit.
- R6: A memory match forwards only with `cmd_mem_en`=1, and an I/O match forwards only with `cmd_io_en`=1.
- R7: `blk_up` is set exactly when `vga_en`=1 and the address is a memory or I/O range match under R1 to R4. It does not depend on the command enable bits.
- R8: A window forward is an I/O request with `win_io_hit` and `cmd_io_en`, or a memory request with (`win_mem_hit` or `win_pf_hit`) and `cmd_mem_en`. With `isa_en`=1, an I/O window hit whose address bits [31:16] are zero and whose bits [9:8] are not 00 is not forwarded.
- R9: `fwd_down` is the OR of the qualified legacy display forward and the qualified window forward.
- R10: Both outputs show the inputs of the previous rising clock edge, and they clear while `rst_n` is low (asynchronous, active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_addr | input | 32 | Request address |
| req_is_io | input | 1 | Address space: 1 = I/O, 0 = memory |
| vga_en | input | 1 | Legacy display range claim enable |
| vga_full_dec | input | 1 | Decode I/O bits [15:10] in full |
| isa_en | input | 1 | ISA alias suppression for I/O window hits |
| cmd_io_en | input | 1 | I/O space enable command bit |
| cmd_mem_en | input | 1 | Memory space enable command bit |
| win_io_hit | input | 1 | I/O base/limit window hit |
| win_mem_hit | input | 1 | Memory base/limit window hit |
| win_pf_hit | input | 1 | Prefetchable base/limit window hit |
| fwd_down | output | 1 | Forward primary request to secondary (registered) |
| blk_up | output | 1 | Block secondary request from primary (registered) |

## Verification
The bench goes after the edges of each range: one address below and one above the memory hole, and 3AFh, 3BBh, 3BCh, 3DFh and 3E0h. A design with an off-by-one compare would claim a neighbouring port or drop a display register. Aliases are tried under both decode settings, where a swapped alias rule either misses FFC0h or claims it under full decode. The bench also drives `isa_en` against the display ports, whose bits [9:8] are 11. A design that let the ISA rule override the display claim would stop forwarding 3C0h. Further cases check that the upstream block ignores the command bits, that the output changes only after one clock edge, and that reset clears both outputs while matching inputs are applied.

// File: rtl/vga_route_pkg.sv
package vga_route_pkg;

   // Low I/O offset bits that carry the legacy port number
   localparam int IO_OFFS_W   = 10;
   // Bits [9:8] pick the upper three quarters of a 1 KB block
   localparam int ISA_SEL_LSB = 8;
   localparam int ISA_SEL_W   = IO_OFFS_W - ISA_SEL_LSB;

   typedef logic [IO_OFFS_W-1:0] io_off_t;

   // Legacy display I/O port windows, inclusive bounds
   localparam int NUM_IO_WIN = 2;
   localparam io_off_t IO_WIN_FIRST [NUM_IO_WIN] = '{10'h3B0, 10'h3C0};
   localparam io_off_t IO_WIN_LAST  [NUM_IO_WIN] = '{10'h3BB, 10'h3DF};

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;

   typedef struct packed {
      logic fwd;
      logic blk;
   } route_t;

endpackage

// File: rtl/vga_mem_range.sv
module vga_mem_range #(
   parameter int                ADDR_W = 32,
   parameter logic [ADDR_W-1:0] LO     = ADDR_W'(32'h000A_0000),
   parameter logic [ADDR_W-1:0] HI     = ADDR_W'(32'h000B_FFFF)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   generate
      if (HI < LO) begin : g_bad_bounds
         $error("vga_mem_range: HI below LO");
      end
   endgenerate

   assign hit = (addr >= LO) && (addr <= HI);

endmodule

// File: rtl/vga_io_range.sv
module vga_io_range
   import vga_route_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IO_SPACE_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              full_dec,
   output logic              hit
);

   localparam int ALIAS_W = IO_SPACE_W - IO_OFFS_W;

   generate
      if (IO_SPACE_W <= IO_OFFS_W || ADDR_W <= IO_SPACE_W) begin : g_bad_w
         $error("vga_io_range: need ADDR_W > IO_SPACE_W > IO_OFFS_W");
      end
   endgenerate

   io_off_t                  offs;
   logic [ALIAS_W-1:0]       alias_bits;
   logic [ADDR_W-IO_SPACE_W-1:0] upper;
   logic [NUM_IO_WIN-1:0]    in_win;
   logic                     alias_ok;

   assign offs       = addr[IO_OFFS_W-1:0];
   assign alias_bits = addr[IO_SPACE_W-1:IO_OFFS_W];
   assign upper      = addr[ADDR_W-1:IO_SPACE_W];

   genvar w;
   generate
      for (w = 0; w < NUM_IO_WIN; w++) begin : g_win
         assign in_win[w] = (offs >= IO_WIN_FIRST[w]) && (offs <= IO_WIN_LAST[w]);
      end
   endgenerate

   // Aliases pass unless full decode asks for a zero alias field
   assign alias_ok = !full_dec || (alias_bits == '0);

   assign hit = (|in_win) && (upper == '0) && alias_ok;

endmodule

// File: rtl/vga_win_qual.sv
module vga_win_qual
   import vga_route_pkg::*;
#(
   parameter int UPPER_W = 16
) (
   input  logic                 is_io,
   input  logic [UPPER_W-1:0]   upper,
   input  logic [ISA_SEL_W-1:0] isa_sel,
   input  logic                 isa_en,
   input  logic                 io_en,
   input  logic                 mem_en,
   input  logic                 win_io,
   input  logic                 win_mem,
   input  logic                 win_pf,
   output logic                 fwd
);

   logic isa_drop;
   logic io_fwd;
   logic mem_fwd;

   // ISA mode drops window I/O hits in the alias-prone part of each 1 KB block
   assign isa_drop = isa_en && (upper == '0) && (isa_sel != '0);
   assign io_fwd   = is_io && win_io && io_en && !isa_drop;
   assign mem_fwd  = !is_io && (win_mem || win_pf) && mem_en;
   assign fwd      = io_fwd || mem_fwd;

endmodule

// File: rtl/vga_out_stage.sv
module vga_out_stage #(
   parameter int W      = 2,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("vga_out_stage: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stg
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/vga_route_dec.sv
module vga_route_dec
   import vga_route_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                IO_SPACE_W = 16,
   parameter logic [ADDR_W-1:0] MEM_LO     = ADDR_W'(32'h000A_0000),
   parameter logic [ADDR_W-1:0] MEM_HI     = ADDR_W'(32'h000B_FFFF),
   parameter int                OUT_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_is_io,
   input  logic              vga_en,
   input  logic              vga_full_dec,
   input  logic              isa_en,
   input  logic              cmd_io_en,
   input  logic              cmd_mem_en,
   input  logic              win_io_hit,
   input  logic              win_mem_hit,
   input  logic              win_pf_hit,
   output logic              fwd_down,
   output logic              blk_up
);

   localparam int UPPER_W = ADDR_W - IO_SPACE_W;

   generate
      if (ADDR_W < 20) begin : g_bad_addr
         $error("vga_route_dec: ADDR_W must cover the display memory hole");
      end
   endgenerate

   space_e space;
   logic   mem_range_hit;
   logic   io_range_hit;
   logic   mem_match;
   logic   io_match;
   logic   vga_claim;
   logic   vga_fwd;
   logic   win_fwd;
   route_t next_route;
   route_t cur_route;

   assign space = space_e'(req_is_io);

   vga_mem_range #(
      .ADDR_W (ADDR_W),
      .LO     (MEM_LO),
      .HI     (MEM_HI)
   ) i_mem_range (
      .addr (req_addr),
      .hit  (mem_range_hit)
   );

   vga_io_range #(
      .ADDR_W     (ADDR_W),
      .IO_SPACE_W (IO_SPACE_W)
   ) i_io_range (
      .addr     (req_addr),
      .full_dec (vga_full_dec),
      .hit      (io_range_hit)
   );

   vga_win_qual #(
      .UPPER_W (UPPER_W)
   ) i_win_qual (
      .is_io   (req_is_io),
      .upper   (req_addr[ADDR_W-1:IO_SPACE_W]),
      .isa_sel (req_addr[IO_OFFS_W-1:ISA_SEL_LSB]),
      .isa_en  (isa_en),
      .io_en   (cmd_io_en),
      .mem_en  (cmd_mem_en),
      .win_io  (win_io_hit),
      .win_mem (win_mem_hit),
      .win_pf  (win_pf_hit),
      .fwd     (win_fwd)
   );

   assign mem_match = (space == SPACE_MEM) && mem_range_hit;
   assign io_match  = (space == SPACE_IO)  && io_range_hit;

   // Upstream block follows the raw claim; downstream needs the command bits
   assign vga_claim = vga_en && (mem_match || io_match);
   assign vga_fwd   = vga_en && ((mem_match && cmd_mem_en) || (io_match && cmd_io_en));

   always_comb begin
      next_route     = '0;
      next_route.fwd = vga_fwd || win_fwd;
      next_route.blk = vga_claim;
   end

   vga_out_stage #(
      .W      ($bits(route_t)),
      .STAGES (OUT_STAGES)
   ) i_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (next_route),
      .q     (cur_route)
   );

   assign fwd_down = cur_route.fwd;
   assign blk_up   = cur_route.blk;

endmodule

// File: rtl/vga_route_chk.sv
module vga_route_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                IO_SPACE_W = 16,
   parameter logic [ADDR_W-1:0] MEM_LO     = ADDR_W'(32'h000A_0000),
   parameter logic [ADDR_W-1:0] MEM_HI     = ADDR_W'(32'h000B_FFFF),
   parameter int                OUT_STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_is_io,
   input logic              vga_en,
   input logic              vga_full_dec,
   input logic              cmd_io_en,
   input logic              cmd_mem_en,
   input logic              fwd_down,
   input logic              blk_up
);

   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   generate
      if (OUT_STAGES == 1) begin : g_one_stage
         // R7
         blk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            blk_up |-> (seen && $past(vga_en)));

         // R2
         io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_up && $past(req_is_io)) |-> ($past(req_addr[ADDR_W-1:IO_SPACE_W]) == '0));

         // R4
         full_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_up && $past(req_is_io) && $past(vga_full_dec))
               |-> ($past(req_addr[IO_SPACE_W-1:10]) == '0));

         // R1
         mem_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_up && !$past(req_is_io))
               |-> (($past(req_addr) >= MEM_LO) && ($past(req_addr) <= MEM_HI)));

         // R6
         cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && !$past(cmd_io_en) && !$past(cmd_mem_en)) |-> !fwd_down);
      end
   endgenerate

endmodule

bind vga_route_dec vga_route_chk #(
   .ADDR_W     (ADDR_W),
   .IO_SPACE_W (IO_SPACE_W),
   .MEM_LO     (MEM_LO),
   .MEM_HI     (MEM_HI),
   .OUT_STAGES (OUT_STAGES)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_addr     (req_addr),
   .req_is_io    (req_is_io),
   .vga_en       (vga_en),
   .vga_full_dec (vga_full_dec),
   .cmd_io_en    (cmd_io_en),
   .cmd_mem_en   (cmd_mem_en),
   .fwd_down     (fwd_down),
   .blk_up       (blk_up)
);

// File: tb/test_vga_route_dec.sv
`timescale 1ns/1ps
module test_vga_route_dec;

   localparam int PERIOD = 20;
   localparam int NV     = 29;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_is_io = 1'b0;
   logic        vga_en = 1'b0;
   logic        vga_full_dec = 1'b0;
   logic        isa_en = 1'b0;
   logic        cmd_io_en = 1'b0;
   logic        cmd_mem_en = 1'b0;
   logic        win_io_hit = 1'b0;
   logic        win_mem_hit = 1'b0;
   logic        win_pf_hit = 1'b0;
   logic        fwd_down;
   logic        blk_up;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   vga_route_dec i_vga_route_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_addr     (req_addr),
      .req_is_io    (req_is_io),
      .vga_en       (vga_en),
      .vga_full_dec (vga_full_dec),
      .isa_en       (isa_en),
      .cmd_io_en    (cmd_io_en),
      .cmd_mem_en   (cmd_mem_en),
      .win_io_hit   (win_io_hit),
      .win_mem_hit  (win_mem_hit),
      .win_pf_hit   (win_pf_hit),
      .fwd_down     (fwd_down),
      .blk_up       (blk_up)
   );

   // {addr, ctrl[io vga full isa ioen memen wio wmem wpf], exp[fwd blk]}
   localparam logic [42:0] VECS [NV] = '{
      {32'h000A_0000, 9'b0_1_0_0_0_1_0_0_0, 2'b11},  // R1 low edge
      {32'h000B_FFFF, 9'b0_1_0_0_0_1_0_0_0, 2'b11},  // R1 high edge
      {32'h0009_FFFF, 9'b0_1_0_0_0_1_0_0_0, 2'b00},  // R1 below
      {32'h000C_0000, 9'b0_1_0_0_0_1_0_0_0, 2'b00},  // R1 above
      {32'h000A_0000, 9'b0_1_0_0_0_0_0_0_0, 2'b01},  // R6 R7 mem off
      {32'h0000_03B0, 9'b1_1_0_0_1_0_0_0_0, 2'b11},  // R2
      {32'h0000_03BB, 9'b1_1_0_0_1_0_0_0_0, 2'b11},  // R2
      {32'h0000_03BC, 9'b1_1_0_0_1_0_0_0_0, 2'b00},  // R2 gap
      {32'h0000_03DF, 9'b1_1_0_0_1_0_0_0_0, 2'b11},  // R2
      {32'h0000_03E0, 9'b1_1_0_0_1_0_0_0_0, 2'b00},  // R2 above
      {32'h0000_03AF, 9'b1_1_0_0_1_0_0_0_0, 2'b00},  // R2 below
      {32'h0000_03C0, 9'b1_1_0_0_1_0_0_0_0, 2'b11},  // R2
      {32'h0001_03C0, 9'b1_1_0_0_1_0_0_0_0, 2'b00},  // R2 upper bits
      {32'h0000_FFC0, 9'b1_1_0_0_1_0_0_0_0, 2'b11},  // R3 alias
      {32'h0000_FFC0, 9'b1_1_1_0_1_0_0_0_0, 2'b00},  // R4 alias refused
      {32'h0000_03C0, 9'b1_1_1_0_1_0_0_0_0, 2'b11},  // R4 zero alias
      {32'h0000_07C0, 9'b1_0_1_0_1_0_1_0_0, 2'b10},  // R4 R8 no claim
      {32'h0000_03C0, 9'b1_1_0_0_0_0_0_0_0, 2'b01},  // R6 R7 io off
      {32'h0000_03C0, 9'b1_1_0_1_1_0_0_0_0, 2'b11},  // R5 isa ignored
      {32'h0000_03C0, 9'b1_0_0_1_1_0_1_0_0, 2'b00},  // R8 isa drop
      {32'h0000_03C0, 9'b1_0_0_0_1_0_1_0_0, 2'b10},  // R5 R8 window
      {32'h0000_1000, 9'b1_0_0_1_1_0_1_0_0, 2'b10},  // R8 low quarter
      {32'h0001_0300, 9'b1_0_0_1_1_0_1_0_0, 2'b10},  // R8 above 64K
      {32'h1000_0000, 9'b0_0_0_0_0_1_0_0_1, 2'b10},  // R8 R9 prefetch
      {32'h1000_0000, 9'b0_0_0_0_0_0_0_1_0, 2'b00},  // R8 mem off
      {32'h000A_0000, 9'b0_0_0_0_0_1_0_0_0, 2'b00},  // R5 no claim
      {32'h000A_0000, 9'b0_1_0_0_0_1_0_1_0, 2'b11},  // R9 both
      {32'h000B_0000, 9'b1_1_0_0_1_1_0_0_0, 2'b00},  // R1 io type
      {32'h000A_0000, 9'b0_1_0_0_1_0_0_0_0, 2'b01}   // R6 wrong enable
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [40:0] v);
      req_addr     = v[40:9];
      req_is_io    = v[8];
      vga_en       = v[7];
      vga_full_dec = v[6];
      isa_en       = v[5];
      cmd_io_en    = v[4];
      cmd_mem_en   = v[3];
      win_io_hit   = v[2];
      win_mem_hit  = v[1];
      win_pf_hit   = v[0];
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset fwd", fwd_down, 1'b0);
      check("R10 reset blk", blk_up, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i][42:2]);
         @(posedge clk);
         @(negedge clk);
         check($sformatf("vec %0d fwd", i), fwd_down, VECS[i][1]);
         check($sformatf("vec %0d blk", i), blk_up, VECS[i][0]);
      end

      // R10 latency: output holds until the next edge
      apply({32'h0000_0000, 9'b0_0_0_0_0_0_0_0_0});
      @(posedge clk);
      @(negedge clk);
      apply({32'h0000_03D5, 9'b1_1_0_0_1_0_0_0_0});
      #2;
      check("R10 before edge fwd", fwd_down, 1'b0);
      check("R10 before edge blk", blk_up, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R10 after edge fwd", fwd_down, 1'b1);
      check("R10 after edge blk", blk_up, 1'b1);

      // R10 async reset with matching inputs held
      rst_n = 1'b0;
      #2;
      check("R10 async clear fwd", fwd_down, 1'b0);
      check("R10 async clear blk", blk_up, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R10 held reset fwd", fwd_down, 1'b0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10 release fwd", fwd_down, 1'b1);

      // R3 R4: alias under decode toggle, full decode ignored without claim
      apply({32'h0000_0BB5, 9'b1_1_0_0_1_0_0_0_0});
      @(posedge clk);
      @(negedge clk);
      check("R3 alias 0BB5 fwd", fwd_down, 1'b1);
      apply({32'h0000_0BB5, 9'b1_0_1_0_1_0_1_0_0});
      @(posedge clk);
      @(negedge clk);
      check("R4 no claim window fwd", fwd_down, 1'b1);
      check("R4 no claim blk", blk_up, 1'b0);

      finish_run();
   end

endmodule